// File: doc/BRIEF.md
# Encrypted Configuration Stream Sequencer

This block accepts a configuration stream one bit per clock and stays silent until it finds the 32-bit synchronisation word. It then interprets a small set of 32-bit command words. These commands choose a key index for the external decryptor, load a 64-bit chaining vector and open a write packet. Packet payload is collected into 64-bit blocks. A flag bit in the write command selects the payload path. With the flag clear, each block goes straight to the configuration write port. With the flag set, each block goes to an external block decryptor, and the decryptor's answer is unchained with the previous ciphertext (or the loaded vector) before it is written.

Decryption of one block runs while the next block is still arriving bit by bit. The stored ciphertext is launched as soon as the second bit of the following block has been captured. The last block of a packet is launched the moment it completes. Every word written to the configuration port feeds a running CRC-16. A check command compares that CRC with a value carried in the stream and raises a sticky error flag on a mismatch.

Top module: `cfg_stream_seq`

## Requirements
- R1: After reset the block is unsynchronised (`synced`=0), and `cfg_we`, `dec_go` and `crc_err` are 0 and `dec_key` is 0.
- R2: Until the bit pattern 0xAA995566 (first bit received = bit 31) has been received, every input bit is ignored: no write, no decryptor launch, `synced` stays 0. Once the pattern is received, `synced` is 1.
- R3: After synchronisation the stream is read as 32-bit command words, first bit = bit 31, with bits [31:24] as the opcode. Opcode 0x0B loads `dec_key` from bits [2:0]. Opcode 0x0C takes the next 64 bits as the chaining vector. Other opcodes that are not write or check opcodes are ignored. A command word equal to 0xAA995566 resynchronises: key index, chaining vector and CRC return to 0 and `crc_err` is cleared.
- R4: Opcode 0x0E opens a plaintext packet of N 64-bit blocks, with N in bits [23:0]. Each block (first bit = bit 63) appears on `cfg_data` with `cfg_we`=1 in the cycle after its last bit is captured, and no `dec_go` is issued.
- R5: Opcode 0x8E (0x0E with bit 31 set) opens an encrypted packet. Each block is presented on `dec_data` with a one-cycle `dec_go` pulse. The word written is `dec_plain` XOR the previous ciphertext block (the chaining vector for the first block), and it appears with `cfg_we` in the cycle after `dec_done`.
- R6: A block that is not the last of its packet is launched (`dec_go`) at the clock edge that captures the second bit of the following block. The last block is launched at the edge that captures its own last bit.
- R7: A CRC with polynomial 0x8005 and seed 0 runs over every written 64-bit word, bit 63 first, from the last synchronisation onward.
- R8: Opcode 0x0F compares bits [15:0] with the CRC. On a mismatch `crc_err` is 1 from the following cycle. On a match `crc_err` is unchanged.
- R9: `crc_err` stays set through any later traffic, including matching checks, until a synchronisation word clears it.
- R10: If a decrypted word is written at the same edge that completes a check command, that word is included in the CRC used by the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial stream bit |
| dec_go | output | 1 | One-cycle launch pulse to the decryptor |
| dec_key | output | KEY_W | Selected key index |
| dec_data | output | 64 | Ciphertext block for the decryptor |
| dec_done | input | 1 | Decryptor result valid, one cycle |
| dec_plain | input | 64 | Decryptor output before unchaining |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_data | output | 64 | Configuration write word |
| synced | output | 1 | Synchronisation word has been seen |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The write-back of the last decrypted word can land at the same edge as the completion of a CRC check command, so the CRC update and the comparison fall in one cycle. The bench provokes this by setting its decryptor model to a 32-cycle latency and sending the check command right after the final encrypted block, so both events meet at one edge. It judges the result in two ways: it confirms that `cfg_we` is high in exactly the cycle after the check word completes, and it confirms that a check value which includes that final word leaves `crc_err` clear.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  localparam int BLK_W  = 64;
  localparam int WORD_W = 32;
  localparam int CRC_W  = 16;

  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;
  localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h8005;

  localparam logic [7:0] OP_KEY = 8'h0B;
  localparam logic [7:0] OP_IV  = 8'h0C;
  localparam logic [7:0] OP_WR  = 8'h0E;
  localparam logic [7:0] OP_CHK = 8'h0F;
  localparam int         ENC_BIT = 31;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_HDR,
    ST_IV,
    ST_PAY
  } seq_state_e;

  // CRC advanced over one whole block, most significant bit first
  function automatic logic [CRC_W-1:0] crc_block(input logic [CRC_W-1:0] c,
                                                 input logic [BLK_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BLK_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_stream_crc.sv
module cfg_stream_crc
  import cfg_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [BLK_W-1:0] data,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nxt
);

  always_comb begin
    crc_nxt = wr ? crc_block(crc_q, data) : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else          crc_q <= crc_nxt;
  end

endmodule

// File: rtl/cfg_stream_chain.sv
module cfg_stream_chain
  import cfg_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             iv_load,
  input  logic [BLK_W-1:0] iv_val,
  input  logic             go,
  input  logic [BLK_W-1:0] go_blk,
  input  logic             dec_done,
  input  logic [BLK_W-1:0] dec_plain,
  output logic             dec_go,
  output logic [BLK_W-1:0] dec_data,
  output logic             busy,
  output logic             wr,
  output logic [BLK_W-1:0] wr_word
);

  logic [BLK_W-1:0] chain_q;

  assign wr      = dec_done && busy;
  assign wr_word = dec_plain ^ chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_go   <= 1'b0;
      dec_data <= '0;
      chain_q  <= '0;
      busy     <= 1'b0;
    end else begin
      dec_go <= go;
      if (go) dec_data <= go_blk;

      if (clr)          chain_q <= '0;
      else if (iv_load) chain_q <= iv_val;
      else if (wr)      chain_q <= dec_data;

      if (clr)           busy <= 1'b0;
      else if (go)       busy <= 1'b1;
      else if (dec_done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
  import cfg_stream_pkg::*;
#(
  parameter int KEY_W = 3,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic             dec_go,
  output logic [KEY_W-1:0] dec_key,
  output logic [63:0]      dec_data,
  input  logic             dec_done,
  input  logic [63:0]      dec_plain,
  output logic             cfg_we,
  output logic [63:0]      cfg_data,
  output logic             synced,
  output logic             crc_err
);

  localparam int            BC_W     = $clog2(BLK_W);
  localparam logic [BC_W-1:0] HDR_LAST = BC_W'(WORD_W - 1);
  localparam logic [BC_W-1:0] BLK_LAST = BC_W'(BLK_W - 1);
  localparam logic [BC_W-1:0] SECOND   = BC_W'(1);

  seq_state_e       st;
  logic [BLK_W-1:0] sr, sr_nxt;
  logic [BC_W-1:0]  cnt;
  logic [CNT_W-1:0] left;
  logic             enc;
  logic [BLK_W-1:0] pend;
  logic             pend_v;
  logic [KEY_W-1:0] key_q;
  logic             err_q;

  // named internal events
  logic [WORD_W-1:0] hword;
  logic              hdr_done, is_sync_word;
  logic              sync_evt, key_evt, iv_evt, wr_evt, chk_evt;
  logic              blk_done, iv_done, second_bit;
  logic              last_blk;
  logic              go_req;
  logic [BLK_W-1:0]  go_blk;
  logic              plain_wr;
  logic              dec_wr;
  logic [BLK_W-1:0]  dec_word;
  logic              wr_any;
  logic [BLK_W-1:0]  wr_word;
  logic              busy;
  logic [CRC_W-1:0]  crc_q, crc_nxt;

  assign sr_nxt       = {sr[BLK_W-2:0], bit_in};
  assign hword        = sr_nxt[WORD_W-1:0];
  assign is_sync_word = (hword == SYNC_WORD);
  assign hdr_done     = bit_en && (st == ST_HDR) && (cnt == HDR_LAST);
  assign sync_evt     = bit_en && is_sync_word &&
                        ((st == ST_HUNT) || (st == ST_HDR && cnt == HDR_LAST));
  assign key_evt      = hdr_done && !is_sync_word && (hword[31:24] == OP_KEY);
  assign iv_evt       = hdr_done && !is_sync_word && (hword[31:24] == OP_IV);
  assign wr_evt       = hdr_done && !is_sync_word &&
                        ({1'b0, hword[30:24]} == OP_WR) && (|hword[CNT_W-1:0]);
  assign chk_evt      = hdr_done && !is_sync_word && (hword[31:24] == OP_CHK);
  assign blk_done     = bit_en && (st == ST_PAY) && (cnt == BLK_LAST);
  assign iv_done      = bit_en && (st == ST_IV)  && (cnt == BLK_LAST);
  assign second_bit   = bit_en && (st == ST_PAY) && (cnt == SECOND) && pend_v;
  assign last_blk     = (left == CNT_W'(1));

  assign go_req   = second_bit || (blk_done && enc && last_blk);
  assign go_blk   = second_bit ? pend : sr_nxt;
  assign plain_wr = blk_done && !enc;
  assign wr_any   = dec_wr || plain_wr;
  assign wr_word  = dec_wr ? dec_word : sr_nxt;

  cfg_stream_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_evt),
    .iv_load   (iv_done),
    .iv_val    (sr_nxt),
    .go        (go_req),
    .go_blk    (go_blk),
    .dec_done  (dec_done),
    .dec_plain (dec_plain),
    .dec_go    (dec_go),
    .dec_data  (dec_data),
    .busy      (busy),
    .wr        (dec_wr),
    .wr_word   (dec_word)
  );

  cfg_stream_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sync_evt),
    .wr      (wr_any),
    .data    (wr_word),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      sr       <= '0;
      cnt      <= '0;
      left     <= '0;
      enc      <= 1'b0;
      pend     <= '0;
      pend_v   <= 1'b0;
      key_q    <= '0;
      err_q    <= 1'b0;
      cfg_we   <= 1'b0;
      cfg_data <= '0;
    end else begin
      cfg_we <= wr_any;
      if (wr_any) cfg_data <= wr_word;
      if (bit_en) sr <= sr_nxt;

      // the compare sees the CRC including a word written at this same edge
      if (chk_evt && (hword[CRC_W-1:0] != crc_nxt)) err_q <= 1'b1;

      if (sync_evt) begin
        st     <= ST_HDR;
        cnt    <= '0;
        left   <= '0;
        enc    <= 1'b0;
        pend_v <= 1'b0;
        key_q  <= '0;
        err_q  <= 1'b0;
      end else if (bit_en) begin
        case (st)
          ST_HDR: begin
            if (cnt == HDR_LAST) begin
              cnt <= '0;
              if (key_evt) key_q <= hword[KEY_W-1:0];
              if (iv_evt)  st <= ST_IV;
              if (wr_evt) begin
                st   <= ST_PAY;
                left <= hword[CNT_W-1:0];
                enc  <= hword[ENC_BIT];
              end
            end else begin
              cnt <= cnt + BC_W'(1);
            end
          end
          ST_IV: begin
            if (cnt == BLK_LAST) begin
              st  <= ST_HDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + BC_W'(1);
            end
          end
          ST_PAY: begin
            cnt <= cnt + BC_W'(1);
            if (second_bit) pend_v <= 1'b0;
            if (cnt == BLK_LAST) begin
              left <= left - CNT_W'(1);
              if (enc && !last_blk) begin
                pend   <= sr_nxt;
                pend_v <= 1'b1;
              end
              if (last_blk) st <= ST_HDR;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dec_key = key_q;
  assign synced  = (st != ST_HUNT);
  assign crc_err = err_q;

endmodule

// File: rtl/cfg_stream_chk.sv
module cfg_stream_chk (
  input logic clk,
  input logic rst_n,
  input logic synced,
  input logic cfg_we,
  input logic dec_go,
  input logic dec_done,
  input logic busy,
  input logic crc_err,
  input logic sync_evt,
  input logic chk_evt
);

  // R2: nothing leaves the block before synchronisation
  a_r2_quiet_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!cfg_we && !dec_go));

  // R5: launch is a single-cycle pulse
  a_r5_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_go |=> !dec_go);

  // R5: no new launch while a block is still in flight
  a_r5_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dec_done) |=> !dec_go);

  // R5: a returned result is written on the next cycle
  a_r5_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dec_done) |=> cfg_we);

  // R8: the error flag only rises after a check command
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(chk_evt));

  // R9: the error flag holds until a sync word
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !sync_evt) |=> crc_err);

  // R9: a sync word clears the flag
  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !crc_err);

endmodule

bind cfg_stream_seq cfg_stream_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .synced   (synced),
  .cfg_we   (cfg_we),
  .dec_go   (dec_go),
  .dec_done (dec_done),
  .busy     (busy),
  .crc_err  (crc_err),
  .sync_evt (sync_evt),
  .chk_evt  (chk_evt)
);

// File: tb/cfg_stream_seq_test.sv
module cfg_stream_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        dec_go;
  logic [2:0]  dec_key;
  logic [63:0] dec_data;
  logic        dec_done = 1'b0;
  logic [63:0] dec_plain = '0;
  logic        cfg_we;
  logic [63:0] cfg_data;
  logic        synced;
  logic        crc_err;

  cfg_stream_seq uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .dec_go(dec_go), .dec_key(dec_key), .dec_data(dec_data),
    .dec_done(dec_done), .dec_plain(dec_plain),
    .cfg_we(cfg_we), .cfg_data(cfg_data), .synced(synced), .crc_err(crc_err)
  );

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_go = 0, nbits = 0, bits_sent = 0;
  int dec_lat = 8;
  bit finished = 0;
  logic [63:0] wr_log [0:63];
  int          go_bits [0:63];
  logic [63:0] pbuf [0:7];
  int          exp_go [0:7];
  logic [15:0] exp_crc = '0;

  initial forever #2 clk = ~clk;

  function automatic logic [63:0] kmask(input logic [2:0] k);
    return {16{k, 1'b1}};
  endfunction

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [63:0] d);
    logic [15:0] r = c;
    logic [63:0] s = d;
    logic        t;
    for (int i = 0; i < 64; i++) begin
      t = r[15] ^ s[63];
      s = s << 1;
      r = r << 1;
      if (t) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = v[i];
      bits_sent++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  // write monitor and bit counter
  initial forever begin
    @(negedge clk);
    if (cfg_we && n_wr < 64) begin
      wr_log[n_wr] = cfg_data;
      n_wr++;
    end
  end
  initial forever begin
    @(posedge clk);
    if (bit_en) nbits++;
  end

  // decryptor model: result = ciphertext ^ key mask after dec_lat cycles
  initial forever begin
    logic [63:0] c;
    logic [2:0]  k;
    @(negedge clk);
    if (dec_go) begin
      if (n_go < 64) go_bits[n_go] = nbits;
      n_go++;
      c = dec_data;
      k = dec_key;
      repeat (dec_lat - 1) @(negedge clk);
      dec_plain = c ^ kmask(k);
      dec_done = 1'b1;
      @(negedge clk);
      dec_done = 1'b0;
    end
  end

  // encrypted packet of nb blocks from pbuf, continuous bits, no idle at end
  task automatic send_enc(input logic [2:0] key, input logic [63:0] iv,
                          input bit with_iv, input int nb);
    logic [63:0] prev, c;
    int s;
    send({8'h0B, 21'd0, key}, 32);
    prev = '0;
    if (with_iv) begin
      send({8'h0C, 24'd0}, 32);
      send(iv, 64);
      prev = iv;
    end
    send({8'h8E, 24'(nb)}, 32);
    for (int j = 0; j < nb; j++) begin
      s = bits_sent;
      exp_go[j] = (j == nb - 1) ? s + 64 : s + 66;
      c = pbuf[j] ^ prev ^ kmask(key);
      send(c, 64);
      prev = c;
      exp_crc = bcrc(exp_crc, pbuf[j]);
    end
  endtask

  task automatic t_reset();
    idle(2);
    ck("R1 synced", 64'(synced), 0);
    ck("R1 cfg_we", 64'(cfg_we), 0);
    ck("R1 dec_go", 64'(dec_go), 0);
    ck("R1 crc_err", 64'(crc_err), 0);
    ck("R1 dec_key", 64'(dec_key), 0);
  endtask

  task automatic t_presync();
    int w0 = n_wr, g0 = n_go;
    send(64'h00AA9955_67AA9955, 64);
    send({8'h0E, 24'd1}, 32);
    send(64'h1234_5678_9ABC_DEF0, 64);
    send({8'h8E, 24'd1}, 32);
    send(64'hFFFF_0000_FFFF_0000, 64);
    idle(4);
    ck("R2 still unsynced", 64'(synced), 0);
    ck("R2 no writes", 64'(n_wr - w0), 0);
    ck("R2 no launches", 64'(n_go - g0), 0);
  endtask

  task automatic t_sync();
    send(32'hAA995566, 32);
    idle(2);
    ck("R2 synced after word", 64'(synced), 1);
    exp_crc = '0;
  endtask

  task automatic t_plain();
    int w0 = n_wr, g0 = n_go;
    pbuf[0] = 64'hDEAD_BEEF_0123_4567;
    pbuf[1] = 64'h8000_0000_0000_0001;
    send({8'h0E, 24'd2}, 32);
    send(pbuf[0], 64);
    send(pbuf[1], 64);
    @(negedge clk);
    bit_en = 1'b0;
    ck("R4 write one cycle after last bit", 64'(cfg_we), 1);
    ck("R4 write data timing", cfg_data, pbuf[1]);
    idle(2);
    ck("R4 write count", 64'(n_wr - w0), 2);
    ck("R4 word 0", wr_log[w0], pbuf[0]);
    ck("R4 word 1", wr_log[w0 + 1], pbuf[1]);
    ck("R4 no launch", 64'(n_go - g0), 0);
    exp_crc = bcrc(bcrc(exp_crc, pbuf[0]), pbuf[1]);
  endtask

  task automatic t_check(input string tag, input logic [15:0] v, input logic exp_err);
    send({8'h0F, 8'd0, v}, 32);
    idle(2);
    ck(tag, 64'(crc_err), 64'(exp_err));
  endtask

  task automatic t_enc();
    int w0 = n_wr, g0 = n_go;
    dec_lat = 8;
    pbuf[0] = 64'h0011_2233_4455_6677;
    pbuf[1] = 64'h8899_AABB_CCDD_EEFF;
    pbuf[2] = 64'hF0F0_0F0F_A5A5_5A5A;
    send_enc(3'd5, 64'h0F1E_2D3C_4B5A_6978, 1'b1, 3);
    idle(dec_lat + 4);
    ck("R3 key index driven", 64'(dec_key), 5);
    ck("R5 launch count", 64'(n_go - g0), 3);
    ck("R5 write count", 64'(n_wr - w0), 3);
    for (int j = 0; j < 3; j++) begin
      ck($sformatf("R5 unchained word %0d", j), wr_log[w0 + j], pbuf[j]);
      ck($sformatf("R6 launch bit position %0d", j), 64'(go_bits[g0 + j]), 64'(exp_go[j]));
    end
  endtask

  task automatic t_collide();
    int w0 = n_wr;
    dec_lat = 32;
    pbuf[0] = 64'hCAFE_F00D_1357_9BDF;
    send_enc(3'd2, 64'h1111_2222_3333_4444, 1'b1, 1);
    send({8'h0F, 8'd0, exp_crc}, 32);
    @(negedge clk);
    bit_en = 1'b0;
    ck("R10 write lands on check edge", 64'(cfg_we), 1);
    idle(2);
    ck("R10 check includes same-cycle word", 64'(crc_err), 0);
    ck("R10 collided word", wr_log[w0], pbuf[0]);
    dec_lat = 8;
  endtask

  task automatic t_sticky();
    int w0;
    t_check("R8 mismatch sets flag", exp_crc ^ 16'h0001, 1'b1);
    w0 = n_wr;
    send({8'h55, 24'h00_0001}, 32);
    pbuf[0] = 64'h0102_0304_0506_0708;
    send({8'h0E, 24'd1}, 32);
    send(pbuf[0], 64);
    idle(3);
    exp_crc = bcrc(exp_crc, pbuf[0]);
    ck("R3 unknown opcode ignored", 64'(n_wr - w0), 1);
    ck("R9 flag held over traffic", 64'(crc_err), 1);
    t_check("R9 flag held over matching check", exp_crc, 1'b1);
    send(32'hAA995566, 32);
    idle(2);
    exp_crc = '0;
    ck("R9 sync clears flag", 64'(crc_err), 0);
    ck("R3 resync clears key", 64'(dec_key), 0);
    t_check("R3 resync clears CRC", 16'h0000, 1'b0);
  endtask

  task automatic t_resync_iv();
    int w0 = n_wr;
    pbuf[0] = 64'h7766_5544_3322_1100;
    send_enc(3'd0, '0, 1'b0, 1);
    idle(dec_lat + 4);
    ck("R3 resync clears chaining vector", wr_log[w0], pbuf[0]);
    t_check("R7 CRC after resync", exp_crc, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_presync();
    t_sync();
    t_plain();
    t_check("R7 CRC over plaintext words", exp_crc, 1'b0);
    t_enc();
    t_check("R7 CRC over decrypted words", exp_crc, 1'b0);
    t_collide();
    t_sticky();
    t_resync_iv();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule